// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block is a byte-wide synchronous serial port that sits on a host CPU bus. It has two registers. The control/status register holds a transfer-complete flag, an interrupt enable, two self-clearing start bits (one for receive, one for transmit) and a clock-select field. The data register is shared by both directions. Software loads a byte into the data register, then sets the transmit start bit. For a receive, software sets the receive start bit and reads the byte once the transfer is done.

The serial clock has two possible sources. One is an internal divider of the system clock, driven out on the serial clock pin. The other is an external clock taken in on that same pin, passed through a two-flop synchronizer and edge-detected in the system clock domain. The pin is split into an output, an output enable and an input, so a pad outside the block forms the bidirectional pin. Each transfer moves exactly one byte, least significant bit first. When the eighth bit is done, the start bit clears itself and the completion flag rises. The flag can raise a level interrupt. Any read or write of the data register clears the flag. A stop input aborts a receive.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, the control register reads 0x00, the interrupt is low, the serial clock output and the serial data output are high, and the clock output enable is high.
- R2: Control register layout. Bit 7 is the completion flag and is read-only. Bit 6 is the interrupt enable, bit 5 starts a receive, bit 4 starts a transmit, bit 3 reads 0, and bits 2:0 are the clock select. All writable fields read back as written.
- R3: A control write with bits 5 and 4 both set is ignored entirely. The two start bits are never 1 together.
- R4: A transmit sends the data register least significant bit first. Each bit is driven on a falling serial clock edge and holds across the following rising edge. The serial data output is high when no transmit is running.
- R5: On every rising serial clock edge of a transfer, the serial input is sampled into the top of the data register and the register shifts toward bit 0. After a receive, the first bit received is therefore bit 0.
- R6: On the system clock edge that follows the eighth rising serial clock edge, the running start bit clears and the completion flag sets, both in that same edge.
- R7: The interrupt output is high exactly when the completion flag and the interrupt enable are both 1.
- R8: A read or a write of the data register clears the completion flag.
- R9: With clock select n in 0..6, the port drives the serial clock pin (output enable high). The clock period is 2^(n+1) system clocks, and the clock idles high.
- R10: With clock select 7, the output enable is low, and bits shift on the edges of the serial clock input, which is synchronized to the system clock.
- R11: The stop input clears the completion flag and the receive start bit, and it aborts a running receive.
- R12: A data register write during a running transfer does not change the byte being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop request, clears flag and receive |
| reg_sel_i | input | 1 | 0 = control/status register, 1 = data register |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data for the selected register |
| irq_o | output | 1 | Level interrupt request |
| sck_o | output | 1 | Serial clock out (internal mode) |
| sck_oe_o | output | 1 | Serial clock pin output enable |
| sck_i | input | 1 | Serial clock in (external mode) |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
A bad bit counter moves the end of the transfer. The flag then appears one serial clock period early or late, and the last bit is dropped or doubled, so the error shows within one byte time when the status register is polled. A wrong shift direction or sampling edge corrupts the byte read back or the bits seen on the data pin, and these are checked bit by bit at each rising clock edge. Flag-clear and interrupt faults show on the next bus cycle. Divider faults show as a wrong spacing between clock edges within three edges of the start.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam int BYTE_W = 8;
  localparam int CKS_W  = 3;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DATA = 1'b1
  } reg_sel_e;

  // control/status bit positions
  localparam int B_DONE = 7;
  localparam int B_IEN  = 6;
  localparam int B_RXGO = 5;
  localparam int B_TXGO = 4;
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CKS_W-1:0] sel,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int EXT_SEL = (1 << CKS_W) - 1;
  localparam int DIV_W   = EXT_SEL - 1;

  logic             ext;
  logic             run_int;
  logic [DIV_W-1:0] div_q, div_d, lim;
  logic             sck_q, sck_d;
  logic             tc;
  logic [2:0]       sync_q, sync_d;

  assign ext     = (sel == CKS_W'(EXT_SEL));
  assign run_int = run & ~ext;
  assign lim     = (DIV_W'(1) << sel) - DIV_W'(1);
  assign tc      = (div_q == lim);

  always_comb begin
    div_d  = div_q;
    sck_d  = sck_q;
    sync_d = {sync_q[1:0], sck_i};
    if (!run_int) begin
      div_d = '0;
      sck_d = 1'b1;
    end else if (tc) begin
      div_d = '0;
      sck_d = ~sck_q;
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      div_q  <= div_d;
      sck_q  <= sck_d;
      sync_q <= sync_d;
    end
  end

  always_comb begin
    if (ext) begin
      rise_o = run & sync_q[1] & ~sync_q[2];
      fall_o = run & ~sync_q[1] & sync_q[2];
    end else begin
      rise_o = run_int & tc & ~sck_q;
      fall_o = run_int & tc & sck_q;
    end
  end

  assign sck_o    = sck_q;
  assign sck_oe_o = ~ext;

  a_r9_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run_int |=> sck_o);
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tx,
  input  logic              rise,
  input  logic              fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int LAST  = DATA_W - 1;

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    sdo_d = sdo_q;
    if (!run) begin
      cnt_d = '0;
      sdo_d = 1'b1;
      if (load) sr_d = load_data;
    end else begin
      if (fall && tx) sdo_d = sr_q[0];
      if (rise) begin
        sr_d  = {sdi, sr_q[DATA_W-1:1]};
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b1;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      sdo_q <= sdo_d;
    end
  end

  assign done_o = run & rise & (cnt_q == CNT_W'(LAST));
  assign data_o = sr_q;
  assign sdo_o  = sdo_q;

  a_r12_hold_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise) |=> $stable(sr_q));
  a_r4_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sdo_o);
endmodule

// File: rtl/sync_shift_port.sv
`timescale 1ns/1ps
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int SEL_W  = CKS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              reg_sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sck_i,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic             done_q, done_d;
  logic             ien_q, ien_d;
  logic             rxgo_q, rxgo_d;
  logic             txgo_q, txgo_d;
  logic [SEL_W-1:0] cks_q, cks_d;

  logic              ctrl_wr, data_wr, data_acc, both_go, ctrl_ok, restart;
  logic              active, run, rise, fall, xfer_done;
  logic [DATA_W-1:0] shreg;
  logic [7:0]        ctrl_view;

  assign ctrl_wr  = wr_i & (reg_sel_i == REG_CTRL);
  assign data_wr  = wr_i & (reg_sel_i == REG_DATA);
  assign data_acc = (wr_i | rd_i) & (reg_sel_i == REG_DATA);
  assign both_go  = wdata_i[B_RXGO] & wdata_i[B_TXGO];
  assign ctrl_ok  = ctrl_wr & ~both_go;
  assign restart  = ctrl_ok & (wdata_i[B_RXGO] | wdata_i[B_TXGO]);
  assign active   = rxgo_q | txgo_q;
  assign run      = active & ~restart;

  ssp_clkgen #(.CKS_W(SEL_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sel      (cks_q),
    .sck_i    (sck_i),
    .sck_o    (sck_o),
    .sck_oe_o (sck_oe_o),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tx        (txgo_q),
    .rise      (rise),
    .fall      (fall),
    .load      (data_wr),
    .load_data (wdata_i),
    .sdi       (sdi_i),
    .data_o    (shreg),
    .sdo_o     (sdo_o),
    .done_o    (xfer_done)
  );

  // next state: bus write, then completion, then stop
  always_comb begin
    done_d = done_q;
    ien_d  = ien_q;
    rxgo_d = rxgo_q;
    txgo_d = txgo_q;
    cks_d  = cks_q;
    if (ctrl_ok) begin
      ien_d  = wdata_i[B_IEN];
      rxgo_d = wdata_i[B_RXGO];
      txgo_d = wdata_i[B_TXGO];
      cks_d  = wdata_i[SEL_W-1:0];
    end
    if (data_acc) done_d = 1'b0;
    if (xfer_done) begin
      done_d = 1'b1;
      rxgo_d = 1'b0;
      txgo_d = 1'b0;
    end
    if (stop_i) begin
      done_d = 1'b0;
      rxgo_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ien_q  <= 1'b0;
      rxgo_q <= 1'b0;
      txgo_q <= 1'b0;
      cks_q  <= '0;
    end else begin
      done_q <= done_d;
      ien_q  <= ien_d;
      rxgo_q <= rxgo_d;
      txgo_q <= txgo_d;
      cks_q  <= cks_d;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[B_DONE] = done_q;
    ctrl_view[B_IEN]  = ien_q;
    ctrl_view[B_RXGO] = rxgo_q;
    ctrl_view[B_TXGO] = txgo_q;
    ctrl_view[SEL_W-1:0] = cks_q;
  end

  assign rdata_o = (reg_sel_i == REG_CTRL) ? DATA_W'(ctrl_view) : shreg;
  assign irq_o   = done_q & ien_q;

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxgo_q && txgo_q));
  a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !stop_i) |=> (done_q && !rxgo_q && !txgo_q));
  a_r8_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !xfer_done) |=> !done_q);
  a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!done_q && !rxgo_q));
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rdata_o[B_DONE] || reg_sel_i == REG_DATA));
endmodule

// File: tb/sync_shift_port_tb.sv
`timescale 1ns/1ps
module sync_shift_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_i = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sck_o, sck_oe, sdo;
  logic       sck_i = 1'b1;
  logic       sdi = 1'b1;

  int nchk = 0;
  int nerr = 0;
  bit done_flag = 0;

  logic [7:0] cap;
  real        trise [8];
  int         ncap = 0;
  bit         mon_en = 0;
  logic [7:0] rx_pat = '0;
  int         drv_idx = 0;
  bit         drv_en = 0;

  always #2.5 clk = ~clk;

  sync_shift_port u_dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .reg_sel_i(reg_sel),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_o(sck_o), .sck_oe_o(sck_oe), .sck_i(sck_i), .sdo_o(sdo), .sdi_i(sdi)
  );

  always @(posedge sck_o) begin
    if (mon_en && ncap < 8) begin
      cap[ncap]   = sdo;
      trise[ncap] = $realtime;
      ncap++;
    end
  end

  always @(negedge sck_o) begin
    if (drv_en && drv_idx < 8) begin
      #1;
      sdi = rx_pat[drv_idx];
      drv_idx++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_flag();
    logic [7:0] v;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(1'b0, v);
      if (v[7]) break;
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(1'b0, v);
    chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sck", sck_o, 1'b1);
    chk("R1 sdo", sdo, 1'b1);
    chk("R1 oe", sck_oe, 1'b1);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] v;
    bus_wr(1'b0, 8'hCD);  // bit7 ro, bit3 reads 0
    bus_rd(1'b0, v);
    chk("R2 readback", v, 8'h45);
    bus_wr(1'b0, 8'h35);  // both start bits: ignored
    bus_rd(1'b0, v);
    chk("R3 both ignored", v, 8'h45);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_tx_internal();
    logic [7:0] v;
    sdi = 1'b1;
    bus_wr(1'b1, 8'h5A);
    ncap = 0; mon_en = 1;
    bus_wr(1'b0, 8'h10);
    wait_flag();
    mon_en = 0;
    chk("R4 tx bits", cap, 8'h5A);
    bus_rd(1'b0, v);
    chk("R6 self clear", v, 8'h80);
    chk("R4 sdo idle", sdo, 1'b1);
    bus_rd(1'b1, v);
    chk("R5 fill from sdi", v, 8'hFF);
    bus_rd(1'b0, v);
    chk("R8 read clears", v, 8'h00);
  endtask

  task automatic t_rx_internal();
    logic [7:0] v;
    rx_pat = 8'hC3; drv_idx = 0; drv_en = 1;
    bus_wr(1'b0, 8'h21);
    wait_flag();
    drv_en = 0;
    bus_rd(1'b0, v);
    chk("R6 rx self clear", v, 8'h81);
    bus_rd(1'b1, v);
    chk("R5 rx byte", v, 8'hC3);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_wr(1'b0, 8'h40);
    chk("R7 no flag", irq, 1'b0);
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b0, 8'h50);
    wait_flag();
    #1 chk("R7 irq set", irq, 1'b1);
    bus_wr(1'b0, 8'h00);
    #1 chk("R7 masked", irq, 1'b0);
    bus_rd(1'b0, v);
    chk("R7 flag kept", v, 8'h80);
    bus_wr(1'b0, 8'h40);
    #1 chk("R7 unmasked", irq, 1'b1);
    bus_wr(1'b1, 8'h11);
    #1 chk("R8 write clears", irq, 1'b0);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_divider();
    real d;
    bus_wr(1'b1, 8'h00);
    ncap = 0; mon_en = 1;
    bus_wr(1'b0, 8'h12);
    #1 chk("R9 oe", sck_oe, 1'b1);
    wait_flag();
    mon_en = 0;
    d = trise[2] - trise[1];
    chk("R9 period n=2", (d > 39.9 && d < 40.1), 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 idle high", sck_o, 1'b1);
    bus_wr(1'b1, 8'h00);
  endtask

  task automatic t_external();
    logic [7:0] v, got;
    logic [7:0] pat;
    pat = 8'h3C;
    bus_wr(1'b0, 8'h07);
    #1 chk("R10 oe low", sck_oe, 1'b0);
    bus_wr(1'b1, 8'h96);
    bus_wr(1'b0, 8'h17);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0;
      repeat (10) @(negedge clk);
      got[i] = sdo;
      sdi = pat[i];
      sck_i = 1'b1;
      repeat (10) @(negedge clk);
    end
    bus_rd(1'b0, v);
    chk("R10 ext done", v, 8'h87);
    chk("R10 ext tx bits", got, 8'h96);
    bus_rd(1'b1, v);
    chk("R10 ext sampled", v, pat);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    bus_wr(1'b0, 8'h23);
    repeat (20) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    bus_rd(1'b0, v);
    chk("R11 stop clears", v, 8'h03);
    repeat (200) @(negedge clk);
    bus_rd(1'b0, v);
    chk("R11 no late flag", v, 8'h03);
    chk("R11 sck idle", sck_o, 1'b1);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_write_busy();
    bus_wr(1'b1, 8'hA5);
    ncap = 0; mon_en = 1;
    bus_wr(1'b0, 8'h12);
    repeat (20) @(negedge clk);
    bus_wr(1'b1, 8'hFF);
    wait_flag();
    mon_en = 0;
    chk("R12 byte unchanged", cap, 8'hA5);
    bus_wr(1'b0, 8'h00);
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_tx_internal();
    t_rx_internal();
    t_irq();
    t_divider();
    t_external();
    t_stop();
    t_write_busy();
    finish_up();
  end
endmodule